// File: doc/BRIEF.md
# Two-Channel Trim Register Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus (I2C) that holds the settings of a two-channel volatile trim controller. The bus lines are brought into the system clock domain and the block watches them for START and STOP conditions. It answers a 7-bit address made of a fixed prefix and three strap inputs. After the address it takes a register address byte. It then either accepts data bytes that it writes into the trim registers, or, after a repeated START with the read bit set, shifts register contents out to the master. The three register values go straight to the wiper logic as parallel outputs. The block drives SDA only through an active-high pull-down enable.

The controller is one state machine. From `ST_IDLE`, a START moves it to `ST_ID_RX`. A matching identification byte leads to `ST_ID_ACK`, and one that does not match leads back to `ST_IDLE`. From `ST_ID_ACK` a write goes on to `ST_ADDR_RX` and a read goes on to `ST_RD_TX`. A valid register address moves `ST_ADDR_RX` to `ST_ADDR_ACK` and then to `ST_WR_RX`; an invalid one moves it to `ST_IDLE`. Each data byte moves `ST_WR_RX` to `ST_WR_ACK`, and the falling edge of the ACK clock returns it to `ST_WR_RX`. On a read, `ST_RD_TX` goes to `ST_RD_ACK` after eight bits. A master ACK there returns to `ST_RD_TX`, and a master NACK goes to `ST_IDLE`. A START in any state jumps to `ST_ID_RX` and a STOP in any state jumps to `ST_IDLE`.

Top module: `i2c_trim_slave`

## Requirements
- R1: After reset, all three registers hold 40h and the SDA pull-down enable is low.
- R2: An identification byte whose upper seven bits equal binary 1010 followed by strap bits 2, 1, 0 is acknowledged; bit 0 selects read (1) or write (0). Any other identification byte is not acknowledged, and the block ignores the bus until the next START.
- R3: The register address byte selects wiper 0 at 00h, wiper 1 at 01h or the control register at 10h and is acknowledged. Any other value is not acknowledged, and the block goes idle with no register changed.
- R4: A received data byte is written into its target register on the rising SCL edge of its ninth (ACK) clock and not before. Wiper registers keep only bits 6:0, so bit 7 is always 0.
- R5: In the control register only bit 6 can be written. Its other bits always read as 0.
- R6: Further data bytes in the same write go to the next register in the order 00h, 01h, 10h, and after 10h back to 00h. Every accepted data byte is acknowledged.
- R7: A read is made of a write of the identification byte and the register address, a repeated START and the identification byte with the read bit. Data goes out MSB first, starting at the addressed register. After each master ACK the next register in the R6 order follows; a master NACK ends the read.
- R8: A STOP sends the block to idle and releases SDA at once, even in the middle of a byte, and it cancels any byte not yet complete. SCL activity without a START has no effect.
- R9: A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP; both are seen after a two-flop synchroniser.
- R10: The pull-down enable is asserted only in the slave's own ACK slots and in read data bits whose value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Strap bits that form the low three address bits |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| wiper0_o | output | 8 | Wiper 0 tap code |
| wiper1_o | output | 8 | Wiper 1 tap code |
| ctrl_o | output | 8 | Control register value |

## Verification
The bench aims at the ninth clock of a data byte. It checks that the register is still old while SCL is low in the ACK slot and new once SCL is high, so a design that wrote after the eighth bit, or only after the ACK clock fell, is caught. It sends addresses one step away from valid ones, identification bytes with one strap bit wrong, and STOPs in the middle of a byte. A design that acknowledged those, or kept a half-received byte, would change registers that must hold. Sequential writes and reads run past 10h to check the wrap back to 00h. Data with bit 7 set, and control data with all bits set, expose a missing mask.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_RX,
        ST_ID_ACK,
        ST_ADDR_RX,
        ST_ADDR_ACK,
        ST_WR_RX,
        ST_WR_ACK,
        ST_RD_TX,
        ST_RD_ACK
    } state_t;

    typedef enum logic [1:0] {
        SEL_W0  = 2'd0,
        SEL_W1  = 2'd1,
        SEL_CTL = 2'd2
    } sel_t;

    // Register walk order for multi-byte transfers: W0 -> W1 -> CTL -> W0
    function automatic sel_t next_sel(input sel_t s);
        sel_t r;
        case (s)
            SEL_W0:  r = SEL_W1;
            SEL_W1:  r = SEL_CTL;
            default: r = SEL_W0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN-1:0] scl_sh, sda_sh;
    logic             scl_prev, sda_prev;
    logic             scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[CHAIN-2:0], scl_i};
            sda_sh   <= {sda_sh[CHAIN-2:0], sda_i};
            scl_prev <= scl_sh[CHAIN-1];
            sda_prev <= sda_sh[CHAIN-1];
        end
    end

    assign scl_s     = scl_sh[CHAIN-1];
    assign sda_s     = sda_sh[CHAIN-1];
    assign sda_o     = sda_s;
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/trim_regs.sv
module trim_regs
    import trim_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL  = 8'h40,
    parameter logic [DATA_W-1:0] WIPER_MASK = 8'h7F,
    parameter logic [DATA_W-1:0] CTL_MASK   = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sel_t              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  sel_t              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wiper0,
    output logic [DATA_W-1:0] wiper1,
    output logic [DATA_W-1:0] ctrl
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = (g == int'(SEL_CTL)) ? CTL_MASK : WIPER_MASK;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[g] <= RESET_VAL & MASK;
            else if (wr_en && (wr_sel == sel_t'(g)))
                regs_q[g] <= wr_data & MASK;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_W0:  rd_data = regs_q[0];
            SEL_W1:  rd_data = regs_q[1];
            SEL_CTL: rd_data = regs_q[2];
            default: rd_data = '0;
        endcase
    end

    assign wiper0 = regs_q[0];
    assign wiper1 = regs_q[1];
    assign ctrl   = regs_q[2];

    // R4: wiper codes never carry bit 7
    a_r4_wiper_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q[0][DATA_W-1] && !regs_q[1][DATA_W-1]);

    // R5: only the writable control bit may ever be set
    a_r5_ctl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[2] & ~CTL_MASK) == '0);

    // R4: a write to wiper 0 lands with the masked value one cycle later
    a_r4_w0_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W0) |=> regs_q[0] == ($past(wr_data) & WIPER_MASK));

    // R8: without a write strobe nothing moves
    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(regs_q[0]) && $stable(regs_q[1]) && $stable(regs_q[2])));

endmodule

// File: rtl/i2c_trim_slave.sv
module i2c_trim_slave
    import trim_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  ID_PREFIX   = 4'b1010,
    parameter logic [7:0]  ADDR_W0     = 8'h00,
    parameter logic [7:0]  ADDR_W1     = 8'h01,
    parameter logic [7:0]  ADDR_CTL    = 8'h10,
    parameter logic [7:0]  RESET_VAL   = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o,
    output logic [7:0] wiper0_o,
    output logic [7:0] wiper1_o,
    output logic [7:0] ctrl_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(DATA_W);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_o     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    state_t             state_q, state_d;
    logic [CNT_W-1:0]   bits_q, bits_d;
    logic [DATA_W-1:0]  shift_q, shift_d;
    logic               oe_q, oe_d;
    logic               rw_q, rw_d;
    sel_t               ptr_q, ptr_d;
    logic               wr_en;
    logic [DATA_W-1:0]  rd_data;

    trim_regs #(.RESET_VAL(RESET_VAL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (ptr_q),
        .wr_data (shift_q),
        .rd_sel  (ptr_q),
        .rd_data (rd_data),
        .wiper0  (wiper0_o),
        .wiper1  (wiper1_o),
        .ctrl    (ctrl_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            shift_q <= '0;
            oe_q    <= 1'b0;
            rw_q    <= 1'b0;
            ptr_q   <= SEL_W0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            shift_q <= shift_d;
            oe_q    <= oe_d;
            rw_q    <= rw_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next-state and output logic
    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        shift_d = shift_q;
        oe_d    = oe_q;
        rw_d    = rw_q;
        ptr_d   = ptr_q;
        wr_en   = 1'b0;

        if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d = ST_ID_RX;
            bits_d  = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ID_RX, ST_ADDR_RX, ST_WR_RX: begin
                    if (scl_rise && bits_q < BYTE_BITS) begin
                        shift_d = {shift_q[DATA_W-2:0], sda_s};
                        bits_d  = bits_q + 1'b1;
                    end else if (scl_fall && bits_q == BYTE_BITS) begin
                        if (state_q == ST_ID_RX) begin
                            if (shift_q[7:1] == {ID_PREFIX, strap_i}) begin
                                rw_d    = shift_q[0];
                                oe_d    = 1'b1;
                                state_d = ST_ID_ACK;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end else if (state_q == ST_ADDR_RX) begin
                            oe_d    = 1'b1;
                            state_d = ST_ADDR_ACK;
                            if (shift_q == ADDR_W0)       ptr_d = SEL_W0;
                            else if (shift_q == ADDR_W1)  ptr_d = SEL_W1;
                            else if (shift_q == ADDR_CTL) ptr_d = SEL_CTL;
                            else begin
                                oe_d    = 1'b0;
                                state_d = ST_IDLE;
                            end
                        end else begin
                            oe_d    = 1'b1;
                            state_d = ST_WR_ACK;
                        end
                    end
                end
                ST_ID_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            shift_d = rd_data;
                            oe_d    = ~rd_data[DATA_W-1];
                            bits_d  = CNT_W'(1);
                            state_d = ST_RD_TX;
                        end else begin
                            oe_d    = 1'b0;
                            bits_d  = '0;
                            state_d = ST_ADDR_RX;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        oe_d    = 1'b0;
                        bits_d  = '0;
                        state_d = ST_WR_RX;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_rise) begin
                        wr_en = 1'b1;
                        ptr_d = next_sel(ptr_q);
                    end else if (scl_fall) begin
                        oe_d    = 1'b0;
                        bits_d  = '0;
                        state_d = ST_WR_RX;
                    end
                end
                ST_RD_TX: begin
                    if (scl_fall) begin
                        if (bits_q == BYTE_BITS) begin
                            oe_d    = 1'b0;
                            state_d = ST_RD_ACK;
                        end else begin
                            shift_d = {shift_q[DATA_W-2:0], 1'b0};
                            oe_d    = ~shift_q[DATA_W-2];
                            bits_d  = bits_q + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) state_d = ST_IDLE;
                        else       ptr_d   = next_sel(ptr_q);
                    end else if (scl_fall) begin
                        shift_d = rd_data;
                        oe_d    = ~rd_data[DATA_W-1];
                        bits_d  = CNT_W'(1);
                        state_d = ST_RD_TX;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign sda_oe_o = oe_q;

    // R8: a STOP releases the line and parks the machine
    a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_o && state_q == ST_IDLE));

    // R10: the line is pulled only in ACK slots or read data bits
    a_r10_oe_slots: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state_q inside {ST_ID_ACK, ST_ADDR_ACK, ST_WR_ACK, ST_RD_TX}));

    // R4: register writes only on the rising clock of the data ACK slot
    a_r4_commit_point: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q == ST_WR_ACK && scl_rise));

    // R8: idle stays released until something happens on the bus
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !sda_oe_o);

endmodule

// File: tb/i2c_trim_slave_tb.sv
module i2c_trim_slave_tb_top;
    localparam time Q = 100ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] w0, w1, ctl;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [3];
    logic [7:0] wbuf [4];

    always #10ns clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_trim_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(strap), .sda_oe_o(sda_oe),
        .wiper0_o(w0), .wiper1_o(w1), .ctrl_o(ctl)
    );

    function automatic logic [7:0] masked(input int idx, input logic [7:0] d);
        return (idx == 2) ? (d & 8'h40) : (d & 8'h7F);
    endfunction
    function automatic int addr_idx(input logic [7:0] a);
        if (a == 8'h00) return 0;
        if (a == 8'h01) return 1;
        if (a == 8'h10) return 2;
        return -1;
    endfunction
    function automatic int nxt(input int i);
        return (i == 2) ? 0 : i + 1;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, w0, mdl[0]);
        chk(req, w1, mdl[1]);
        chk(req, ctl, mdl[2]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask
    task automatic bit_out(input logic b);
        sda_m = b; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
    endtask
    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; #Q; scl = 1'b1; #Q;
        acked = !sda_line;
        #Q; scl = 1'b0; #Q;
    endtask
    task automatic recv_byte(input logic mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; scl = 1'b1; #Q; d[i] = sda_line; #Q; scl = 1'b0;
        end
        #Q; sda_m = !mack; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
    endtask

    // Write transaction; id_strap may differ from the strap pins
    task automatic write_frame(input logic [2:0] id_strap, input logic [7:0] addr, input int n);
        logic ack;
        logic ok;
        int   p;
        bus_start();
        send_byte({4'b1010, id_strap, 1'b0}, ack);
        ok = (id_strap == strap);
        chk("R2 id ack", {7'd0, ack}, {7'd0, ok});
        send_byte(addr, ack);
        p  = addr_idx(addr);
        ok = ok && (p >= 0);
        chk("R3 addr ack", {7'd0, ack}, {7'd0, ok});
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk("R6 data ack", {7'd0, ack}, {7'd0, ok});
            if (ok) begin
                mdl[p] = masked(p, wbuf[i]);
                p = nxt(p);
            end
        end
        bus_stop();
        #Q;
        chk_regs("R4 R5 R6 regs after write");
        chk("R8 released after stop", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic read_frame(input logic [7:0] addr, input int n);
        logic       ack;
        logic [7:0] d;
        int         p;
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, ack);
        send_byte(addr, ack);
        bus_start();
        send_byte({4'b1010, strap, 1'b1}, ack);
        chk("R7 read id ack", {7'd0, ack}, 8'd1);
        p = addr_idx(addr);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            chk("R7 read data", d, mdl[p]);
            p = nxt(p);
        end
        bus_stop();
        #Q;
        chk("R7 released after read", {7'd0, sda_oe}, 8'd0);
    endtask

    initial begin : watchdog
        #(190000 * 20ns);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic       ack;
        logic [7:0] a;
        int         seen;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) mdl[i] = (i == 2) ? 8'h40 : 8'h40;
        #(5 * Q);
        chk("R1 reset oe", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1;
        #(2 * Q);
        chk_regs("R1 reset values");

        // R4 commit point: old value in ACK low phase, new after the rising edge
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h00, ack);
        for (int i = 7; i >= 0; i--) bit_out(8'hD5 >> i);
        sda_m = 1'b1; #Q;
        chk("R4 before ninth rise", w0, 8'h40);
        scl = 1'b1; #Q;
        chk("R4 ack slot pulled", {7'd0, sda_line}, 8'd0);
        chk("R4 after ninth rise masked", w0, 8'h55);
        #Q; scl = 1'b0; #Q;
        bus_stop();
        mdl[0] = 8'h55;

        // R5 control register masking
        wbuf[0] = 8'hFF; write_frame(strap, 8'h10, 1);
        wbuf[0] = 8'h00; write_frame(strap, 8'h10, 1);
        // R6 wrap across all registers
        wbuf[0] = 8'h81; wbuf[1] = 8'hFF; wbuf[2] = 8'h3C; wbuf[3] = 8'h12;
        write_frame(strap, 8'h01, 4);
        // R7 read wrapping past 10h
        read_frame(8'h10, 4);
        // R2 wrong strap bit, R3 near-miss addresses
        strap = 3'b101;
        wbuf[0] = 8'h11; write_frame(3'b100, 8'h00, 1);
        write_frame(strap, 8'h02, 1);
        write_frame(strap, 8'h11, 1);
        write_frame(strap, 8'h00, 1);

        // R8/R9 STOP in the middle of a data byte cancels it
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, ack);
        send_byte(8'h01, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        bus_stop();
        #Q;
        chk_regs("R9 stop mid byte");
        chk("R8 stop mid byte oe", {7'd0, sda_oe}, 8'd0);

        // R8 clocking without START is ignored
        seen = 0;
        for (int i = 0; i < 27; i++) begin
            sda_m = (i % 3 == 0) ? 1'b0 : 1'b1;
            #Q; scl = 1'b1; #Q;
            if (sda_oe) seen++;
            #Q; scl = 1'b0; #Q;
        end
        sda_m = 1'b1; #Q;
        chk("R8 no response without start", 8'(seen), 8'd0);
        chk_regs("R8 regs after idle clocks");

        // Constrained random mix
        for (int it = 0; it < 36; it++) begin
            int kind;
            int n;
            kind = $urandom % 4;
            n = 1 + ($urandom % 4);
            for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
            case ($urandom % 3)
                0: a = 8'h00;
                1: a = 8'h01;
                default: a = 8'h10;
            endcase
            if (kind == 0) begin
                strap = 3'($urandom);
                write_frame(strap, a, n);
            end else if (kind == 1) begin
                read_frame(a, n);
            end else if (kind == 2) begin
                write_frame(strap ^ (3'b001 << ($urandom % 3)), a, n);
            end else begin
                write_frame(strap, 8'($urandom) | 8'h02, n);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule